// File: doc/BRIEF.md
# Converter Code-Density Linearity Analyzer

This block measures the static linearity of an 8-bit analog-to-digital converter by code-density counting. While a slow triangle ramp sweeps the converter across its full range, every valid output code increments one bin of a 256-entry hit histogram held in on-chip RAM. Accumulation starts on a start pulse and stops by itself once a programmed number of ramp-period strobes have arrived.

When collection ends, the block walks the histogram from code 0 to code 255. For each code it streams out the raw hit count, a differential linearity error and an integral linearity error, and it flags the last code. The differential error is kept in a divider-free scaled form. The ideal step width is the mean hit count of the interior codes 1 to 254. The two end codes are left out because they collect all overrange samples. The block also keeps the signed differential error of the worst step, for use as the DNL figure.

A clear pass zeroes the histogram before each measurement. Samples that arrive while the block is busy with a clear, a drain or a readout are dropped and counted. A bin that reaches full scale stops counting and raises a sticky flag.

Top module: `adc_hist_linearity`

## Requirements
- R1: A clear_req accepted while idle writes zero to all 256 bins, and busy stays high for exactly 256 cycles, starting the cycle after the request.
- R2: Each cycle with code_valid high while busy is high drops that sample and adds one to overrun_cnt, which saturates at all ones and is cleared only by reset.
- R3: After a start_req accepted while idle, collecting is high. Each cycle with code_valid high then adds one to the bin of code_in, and back-to-back samples of the same code are each counted.
- R4: Collection ends in the cycle carrying the Nth period_mark, where N is period_cfg as sampled at start (0 acts as 1). A sample in that same cycle is still counted, and collecting is low from the next cycle.
- R5: Samples presented while idle (neither busy nor collecting) change no bin and do not change overrun_cnt.
- R6: A bin at 2^BIN_W-1 keeps that value on further hits. Such a hit sets sat_flag, which stays set until the next accepted start_req, and is not added to the interior total.
- R7: After collection ends, results for codes 0 to 255 come out in ascending order on 256 consecutive cycles with res_valid high. res_last is high only with code 255, busy is still high in that cycle, and busy is low in the cycle after it.
- R8: For codes 1 to 254, res_dle = hits*254 - T, where T is the sum of the hits of codes 1 to 254. For codes 0 and 255, res_dle is 0.
- R9: res_ile is 0 for code 0. For code k in 1 to 254 it is the sum of res_dle over codes 1 to k. Code 255 repeats the value of code 254.
- R10: From the res_last cycle until the next readout, worst_dle holds the res_dle of largest magnitude among codes 1 to 254, with the lowest such code winning a tie.
- R11: After reset, busy, collecting, res_valid, res_last and sat_flag are low, and overrun_cnt is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_req | input | 1 | Pulse: zero the histogram (idle only, wins over start) |
| start_req | input | 1 | Pulse: begin a collection run (idle only) |
| period_cfg | input | PER_W | Number of ramp periods to accumulate |
| code_valid | input | 1 | code_in carries a converter sample |
| code_in | input | CODE_W | Converter output code |
| period_mark | input | 1 | Ramp period boundary strobe |
| busy | output | 1 | Clear, drain or readout in progress |
| collecting | output | 1 | Histogram accumulation active |
| overrun_cnt | output | OVR_W | Samples dropped while busy |
| sat_flag | output | 1 | Sticky: some bin hit full scale |
| res_valid | output | 1 | Result fields valid |
| res_code | output | CODE_W | Code of the current result |
| res_hits | output | BIN_W | Hit count of that code |
| res_dle | output | BIN_W+CODE_W+1 | Signed scaled differential error |
| res_ile | output | BIN_W+2*CODE_W+1 | Signed running integral error |
| res_last | output | 1 | Result is for the top code |
| worst_dle | output | BIN_W+CODE_W+1 | Signed differential error of the worst step |

## Verification
A bin that is updated from a stale read shows up as a short res_hits value. The value is wrong for a code that was fed repeatedly on consecutive cycles, and it is seen only at readout, many cycles later. An error in the running total or the accumulator moves every res_dle of the run by the same amount, and it leaves res_ile nonzero at code 254, which makes it visible within the same readout stream. A fault in the period or sequencing logic appears at once in the cycle timing of collecting, busy and res_last.

// File: rtl/hist_lin_pkg.sv
package hist_lin_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_COLLECT,
    ST_DRAIN,
    ST_READ,
    ST_TAIL
  } hl_state_e;
endpackage

// File: rtl/hist_bank.sv
module hist_bank #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-before-write: a same-cycle write is not seen here
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hit_updater.sv
module hit_updater #(
  parameter int CODE_W = 8,
  parameter int BIN_W  = 16,
  parameter int TOT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  input  logic [BIN_W-1:0]  rd_data,
  output logic              wr_en,
  output logic [CODE_W-1:0] wr_addr,
  output logic [BIN_W-1:0]  wr_data,
  output logic [TOT_W-1:0]  total,
  output logic              sat_flag
);
  logic              s1_valid;
  logic [CODE_W-1:0] s1_code;
  logic              lw_valid;
  logic [CODE_W-1:0] lw_addr;
  logic [BIN_W-1:0]  lw_data;
  logic [BIN_W-1:0]  cur;
  logic              at_max;
  logic              interior;

  always_comb begin
    cur      = (lw_valid && (lw_addr == s1_code)) ? lw_data : rd_data;
    at_max   = &cur;
    interior = (s1_code != '0) && (s1_code != '1);
    wr_en    = s1_valid;
    wr_addr  = s1_code;
    wr_data  = at_max ? cur : cur + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_code  <= '0;
      lw_valid <= 1'b0;
      lw_addr  <= '0;
      lw_data  <= '0;
      total    <= '0;
      sat_flag <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_code  <= in_code;
      lw_valid <= wr_en;
      lw_addr  <= wr_addr;
      lw_data  <= wr_data;
      if (start) begin
        total    <= '0;
        sat_flag <= 1'b0;
      end else if (s1_valid) begin
        if (at_max) sat_flag <= 1'b1;
        else if (interior) total <= total + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lin_calc.sv
module lin_calc #(
  parameter int CODE_W = 8,
  parameter int BIN_W  = 16,
  parameter int TOT_W  = 24,
  parameter int DLE_W  = 25,
  parameter int ILE_W  = 33
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [CODE_W-1:0]       in_code,
  input  logic [BIN_W-1:0]        in_hits,
  input  logic [TOT_W-1:0]        total,
  output logic                    res_valid,
  output logic [CODE_W-1:0]       res_code,
  output logic [BIN_W-1:0]        res_hits,
  output logic signed [DLE_W-1:0] res_dle,
  output logic signed [ILE_W-1:0] res_ile,
  output logic                    res_last,
  output logic signed [DLE_W-1:0] worst_dle
);
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int IDEAL_DIV = NUM_CODES - 2;

  logic signed [DLE_W-1:0] scaled, tot_s, dle_c, mag_c, mag_w;
  logic signed [ILE_W-1:0] acc, ile_c;
  logic                    interior;

  always_comb begin
    interior = (in_code != '0) && (in_code != '1);
    scaled   = $signed(DLE_W'(in_hits)) * $signed(DLE_W'(IDEAL_DIV));
    tot_s    = $signed(DLE_W'(total));
    dle_c    = interior ? scaled - tot_s : '0;
    ile_c    = (in_code == '0) ? '0 : acc + ILE_W'(dle_c);
    mag_c    = dle_c[DLE_W-1] ? -dle_c : dle_c;
    mag_w    = worst_dle[DLE_W-1] ? -worst_dle : worst_dle;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_code  <= '0;
      res_hits  <= '0;
      res_dle   <= '0;
      res_ile   <= '0;
      res_last  <= 1'b0;
      acc       <= '0;
      worst_dle <= '0;
    end else begin
      res_valid <= in_valid;
      res_last  <= in_valid && (in_code == '1);
      if (in_valid) begin
        res_code <= in_code;
        res_hits <= in_hits;
        res_dle  <= dle_c;
        res_ile  <= ile_c;
        acc      <= ile_c;
        if (in_code == '0) worst_dle <= '0;
        else if (interior && (mag_c > mag_w)) worst_dle <= dle_c;
      end
    end
  end
endmodule

// File: rtl/adc_hist_linearity.sv
module adc_hist_linearity
  import hist_lin_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int BIN_W  = 16,
  parameter int PER_W  = 8,
  parameter int OVR_W  = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            clear_req,
  input  logic                            start_req,
  input  logic [PER_W-1:0]                period_cfg,
  input  logic                            code_valid,
  input  logic [CODE_W-1:0]               code_in,
  input  logic                            period_mark,
  output logic                            busy,
  output logic                            collecting,
  output logic [OVR_W-1:0]                overrun_cnt,
  output logic                            sat_flag,
  output logic                            res_valid,
  output logic [CODE_W-1:0]               res_code,
  output logic [BIN_W-1:0]                res_hits,
  output logic signed [BIN_W+CODE_W:0]    res_dle,
  output logic signed [BIN_W+2*CODE_W:0]  res_ile,
  output logic                            res_last,
  output logic signed [BIN_W+CODE_W:0]    worst_dle
);
  localparam int TOT_W = BIN_W + CODE_W;
  localparam int DLE_W = BIN_W + CODE_W + 1;
  localparam int ILE_W = DLE_W + CODE_W;

  hl_state_e         state;
  logic [CODE_W-1:0] clr_ptr;
  logic [CODE_W-1:0] rptr;
  logic [PER_W-1:0]  per_cnt;
  logic [PER_W-1:0]  per_target;
  logic              per_done;
  logic              rq_valid;
  logic [CODE_W-1:0] rq_code;

  logic              upd_start, upd_valid, upd_we;
  logic [CODE_W-1:0] upd_addr;
  logic [BIN_W-1:0]  upd_data;
  logic [TOT_W-1:0]  total;

  logic              mem_we;
  logic [CODE_W-1:0] mem_waddr, mem_raddr;
  logic [BIN_W-1:0]  mem_wdata, mem_rdata;

  always_comb begin
    busy       = (state == ST_CLEAR) || (state == ST_DRAIN) ||
                 (state == ST_READ)  || (state == ST_TAIL);
    collecting = (state == ST_COLLECT);
    per_done   = period_mark &&
                 (({1'b0, per_cnt} + 1'b1) >= {1'b0, per_target});
    upd_start  = (state == ST_IDLE) && start_req && !clear_req;
    upd_valid  = collecting && code_valid;
    mem_we     = (state == ST_CLEAR) || upd_we;
    mem_waddr  = (state == ST_CLEAR) ? clr_ptr : upd_addr;
    mem_wdata  = (state == ST_CLEAR) ? '0 : upd_data;
    mem_raddr  = (state == ST_READ) ? rptr : code_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      clr_ptr    <= '0;
      rptr       <= '0;
      per_cnt    <= '0;
      per_target <= '0;
      rq_valid   <= 1'b0;
      rq_code    <= '0;
    end else begin
      rq_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (clear_req) begin
            clr_ptr <= '0;
            state   <= ST_CLEAR;
          end else if (start_req) begin
            per_cnt    <= '0;
            per_target <= period_cfg;
            state      <= ST_COLLECT;
          end
        end
        ST_CLEAR: begin
          clr_ptr <= clr_ptr + 1'b1;
          if (clr_ptr == '1) state <= ST_IDLE;
        end
        ST_COLLECT: begin
          if (period_mark) begin
            per_cnt <= per_cnt + 1'b1;
            if (per_done) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          rptr  <= '0;
          state <= ST_READ;
        end
        ST_READ: begin
          rq_valid <= 1'b1;
          rq_code  <= rptr;
          rptr     <= rptr + 1'b1;
          if (rptr == '1) state <= ST_TAIL;
        end
        ST_TAIL: begin
          if (res_last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) overrun_cnt <= '0;
    else if (busy && code_valid && (overrun_cnt != '1))
      overrun_cnt <= overrun_cnt + 1'b1;
  end

  hist_bank #(.AW(CODE_W), .DW(BIN_W)) u_bank (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  hit_updater #(.CODE_W(CODE_W), .BIN_W(BIN_W), .TOT_W(TOT_W)) u_upd (
    .clk      (clk),
    .rst      (rst),
    .start    (upd_start),
    .in_valid (upd_valid),
    .in_code  (code_in),
    .rd_data  (mem_rdata),
    .wr_en    (upd_we),
    .wr_addr  (upd_addr),
    .wr_data  (upd_data),
    .total    (total),
    .sat_flag (sat_flag)
  );

  lin_calc #(
    .CODE_W(CODE_W), .BIN_W(BIN_W), .TOT_W(TOT_W),
    .DLE_W(DLE_W), .ILE_W(ILE_W)
  ) u_calc (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rq_valid),
    .in_code   (rq_code),
    .in_hits   (mem_rdata),
    .total     (total),
    .res_valid (res_valid),
    .res_code  (res_code),
    .res_hits  (res_hits),
    .res_dle   (res_dle),
    .res_ile   (res_ile),
    .res_last  (res_last),
    .worst_dle (worst_dle)
  );
endmodule

// File: rtl/hist_lin_checker.sv
module hist_lin_checker #(
  parameter int CODE_W = 8,
  parameter int BIN_W  = 16,
  parameter int OVR_W  = 16
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           clear_req,
  input logic                           start_req,
  input logic                           busy,
  input logic                           collecting,
  input logic [OVR_W-1:0]               overrun_cnt,
  input logic                           sat_flag,
  input logic                           res_valid,
  input logic [CODE_W-1:0]              res_code,
  input logic signed [BIN_W+CODE_W:0]   res_dle,
  input logic                           res_last
);
  // R1
  clear_busy_chk: assert property (@(posedge clk) disable iff (rst)
    clear_req && !busy && !collecting |=> busy);

  // R2
  overrun_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(overrun_cnt) |-> overrun_cnt == $past(overrun_cnt) + 1'b1);

  // R4
  exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(collecting && busy));

  // R6
  sat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sat_flag && !(start_req && !clear_req && !busy && !collecting) |=> sat_flag);

  // R7
  last_code_chk: assert property (@(posedge clk) disable iff (rst)
    res_last |-> res_valid && (res_code == '1));

  // R7
  res_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> busy);

  // R8
  end_dle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && ((res_code == '0) || (res_code == '1)) |-> res_dle == '0);
endmodule

bind adc_hist_linearity hist_lin_checker #(
  .CODE_W(CODE_W), .BIN_W(BIN_W), .OVR_W(OVR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .clear_req   (clear_req),
  .start_req   (start_req),
  .busy        (busy),
  .collecting  (collecting),
  .overrun_cnt (overrun_cnt),
  .sat_flag    (sat_flag),
  .res_valid   (res_valid),
  .res_code    (res_code),
  .res_dle     (res_dle),
  .res_last    (res_last)
);

// File: tb/test_adc_hist_linearity.sv
`timescale 1ns/1ps
module test_adc_hist_linearity;
  localparam int CW = 8;
  localparam int BW = 8;
  localparam int PW = 8;
  localparam int OW = 16;
  localparam int DW = BW + CW + 1;
  localparam int IW = DW + CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clear_req = 1'b0, start_req = 1'b0;
  logic [PW-1:0] period_cfg = '0;
  logic code_valid = 1'b0, period_mark = 1'b0;
  logic [CW-1:0] code_in = '0;
  logic busy, collecting, sat_flag, res_valid, res_last;
  logic [OW-1:0] overrun_cnt;
  logic [CW-1:0] res_code;
  logic [BW-1:0] res_hits;
  logic signed [DW-1:0] res_dle, worst_dle;
  logic signed [IW-1:0] res_ile;

  int n_chk = 0, n_fail = 0;
  int exp_hits [256];
  int exp_ovr = 0;

  always #2 clk = ~clk;

  adc_hist_linearity #(.CODE_W(CW), .BIN_W(BW), .PER_W(PW), .OVR_W(OW)) i_adc_hist_linearity (
    .clk(clk), .rst(rst), .clear_req(clear_req), .start_req(start_req),
    .period_cfg(period_cfg), .code_valid(code_valid), .code_in(code_in),
    .period_mark(period_mark), .busy(busy), .collecting(collecting),
    .overrun_cnt(overrun_cnt), .sat_flag(sat_flag), .res_valid(res_valid),
    .res_code(res_code), .res_hits(res_hits), .res_dle(res_dle),
    .res_ile(res_ile), .res_last(res_last), .worst_dle(worst_dle)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int c, input logic m);
    @(negedge clk);
    code_valid  = v;
    code_in     = CW'(c);
    period_mark = m;
    clear_req   = 1'b0;
    start_req   = 1'b0;
  endtask

  // count a sample into the model (collection phase only)
  task automatic feed(input int c, input logic m);
    drive(1'b1, c, m);
    if (exp_hits[c] < 255) exp_hits[c]++;
  endtask

  task automatic start_run(input int n);
    @(negedge clk);
    start_req = 1'b1; period_cfg = PW'(n); code_valid = 1'b0; period_mark = 1'b0;
    @(negedge clk);
    start_req = 1'b0;
    chk("R3 collecting after start", collecting, 1);
  endtask

  task automatic do_readout(input string tag);
    longint total = 0, acc = 0, dle, worst = 0, mw, md;
    int w = 0;
    for (int c = 1; c < 255; c++) total += exp_hits[c];
    while (!res_valid && w < 20) begin
      @(negedge clk);
      w++;
    end
    for (int k = 0; k < 256; k++) begin
      dle = (k == 0 || k == 255) ? 0 : exp_hits[k] * 254 - total;
      if (k != 0) acc += dle;
      md = dle < 0 ? -dle : dle;
      mw = worst < 0 ? -worst : worst;
      if (md > mw) worst = dle;
      chk({tag, " R7 valid"}, res_valid, 1);
      chk({tag, " R7 code order"}, res_code, k);
      chk({tag, " R3 hits"}, res_hits, exp_hits[k]);
      chk({tag, " R8 dle"}, longint'(res_dle), dle);
      chk({tag, " R9 ile"}, longint'(res_ile), acc);
      chk({tag, " R7 last"}, res_last, (k == 255) ? 1 : 0);
      if (k == 255) begin
        chk({tag, " R7 busy at last"}, busy, 1);
        chk({tag, " R10 worst"}, longint'(worst_dle), worst);
      end
      @(negedge clk);
    end
    chk({tag, " R7 busy drops"}, busy, 0);
    chk({tag, " R7 valid drops"}, res_valid, 0);
  endtask

  task automatic t_reset_state;
    chk("R11 busy", busy, 0);
    chk("R11 collecting", collecting, 0);
    chk("R11 res_valid", res_valid, 0);
    chk("R11 res_last", res_last, 0);
    chk("R11 sat", sat_flag, 0);
    chk("R11 overrun", overrun_cnt, 0);
  endtask

  task automatic t_clear;
    int cnt = 0;
    @(negedge clk);
    clear_req = 1'b1;
    @(negedge clk);
    clear_req = 1'b0;
    while (busy && cnt < 1000) begin
      cnt++;
      code_valid = (cnt <= 5);
      code_in = 8'd40;
      @(negedge clk);
    end
    code_valid = 1'b0;
    if (cnt > 5) exp_ovr += 5; else exp_ovr += cnt;
    chk("R1 busy length", cnt, 256);
    chk("R2 overrun during clear", overrun_cnt, exp_ovr);
    for (int c = 0; c < 256; c++) exp_hits[c] = 0;
  endtask

  task automatic t_zero_bins;
    t_clear();
    start_run(1);
    drive(1'b0, 0, 1'b1);
    drive(1'b0, 0, 1'b0);
    do_readout("zero");
  endtask

  task automatic t_ramp;
    t_clear();
    for (int i = 0; i < 3; i++) drive(1'b1, 5, 1'b0);
    drive(1'b0, 0, 1'b0);
    chk("R5 idle no overrun", overrun_cnt, exp_ovr);
    start_run(3);
    for (int p = 0; p < 3; p++)
      for (int c = 0; c < 256; c++)
        for (int r = 0; r <= (c * 7 + p) % 4; r++)
          feed(c, (c == 255 && r == (c * 7 + p) % 4) ? 1'b1 : 1'b0);
    drive(1'b1, 9, 1'b0);
    drive(1'b1, 9, 1'b0);
    drive(1'b0, 0, 1'b0);
    exp_ovr += 2;
    chk("R4 collecting low after last mark", collecting, 0);
    do_readout("ramp");
    chk("R2 overrun after end", overrun_cnt, exp_ovr);
  endtask

  task automatic t_saturation;
    t_clear();
    start_run(1);
    chk("R6 sat cleared", sat_flag, 0);
    for (int i = 0; i < 300; i++) feed(7, 1'b0);
    for (int i = 0; i < 5; i++) feed(9, 1'b0);
    feed(0, 1'b0);
    feed(0, 1'b0);
    drive(1'b0, 0, 1'b1);
    drive(1'b0, 0, 1'b0);
    chk("R6 sat set", sat_flag, 1);
    do_readout("sat");
    chk("R6 sat sticky", sat_flag, 1);
  endtask

  task automatic t_periods;
    t_clear();
    start_run(2);
    chk("R6 sat cleared by start", sat_flag, 0);
    feed(3, 1'b0);
    feed(3, 1'b1);
    drive(1'b0, 0, 1'b0);
    chk("R4 still collecting after mark 1", collecting, 1);
    feed(4, 1'b0);
    feed(4, 1'b0);
    feed(4, 1'b1);
    drive(1'b0, 0, 1'b0);
    chk("R4 stops on mark 2", collecting, 0);
    do_readout("per");
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_zero_bins();
    t_ramp();
    t_saturation();
    t_periods();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule